// File: doc/BRIEF.md
# Clock Output Divider Network

This block is the digital back end of a phase-locked clock fan-out buffer. One source clock is chosen from three: the oscillator clock when phase-lock operation is on, or else one of two reference clocks picked by a select input. The chosen clock may pass through an optional extra divide-by-2 stage. It then steps a single 3-bit binary counter. Bit 0 of the counter is the double-rate output. Bit 1 feeds a bank of five identical main clocks and one inverted copy. Bit 2 is the half-rate output. Because every output comes from the same counter, their edges stay aligned.

The active-low enable/reset input does two jobs. While it is low, every output is released to high impedance and the counter and prescaler are cleared asynchronously. In bypass mode, when phase-lock operation is off, every output takes the opposite polarity to the one it has in normal mode. A per-output enable vector is brought out next to the three-state pins, so the drive state can be seen directly.

Top module: `clk_fanout_div`

## Requirements
- R1: With `lock_run`=0 the source clock is `ref_b` when `ref_pick`=1 and `ref_a` when `ref_pick`=0.
- R2: With `lock_run`=1 the source clock is `osc_clk`, whatever the value of `ref_pick`.
- R3: The double-rate output `dbl_q` changes value on every counter step. In ÷1 mode a step occurs on every source rising edge.
- R4: Every main output changes value only when the double-rate phase falls, so the main outputs run at half the rate of `dbl_q`.
- R5: `half_q` changes value only when the main phase falls, so it runs at half the main rate.
- R6: With `div_more`=1 the counter steps only on source rising edges 1, 3, 5, … counted from the release of reset, which halves every output rate.
- R7: With `lock_run`=0 every output is the inverse of the value it would have with `lock_run`=1 for the same counter state.
- R8: `bank_q[0]` to `bank_q[4]` are always equal, and `bank_qn` is always their inverse.
- R9: While `oe_rst_n`=0, `out_en` is all zeros and every clock output is high impedance. Bits [4:0] of `out_en` enable `bank_q`, bit 5 enables `bank_qn`, bit 6 enables `dbl_q` and bit 7 enables `half_q`. While `oe_rst_n`=1, `out_en` is all ones.
- R10: While `oe_rst_n`=0 the counter and prescaler are held at 0. After release, the first counter step comes on the first source rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock used in phase-lock mode |
| ref_a | input | 1 | Reference clock, choice 0 |
| ref_b | input | 1 | Reference clock, choice 1 |
| ref_pick | input | 1 | Reference select (1 selects `ref_b`) |
| lock_run | input | 1 | 1 selects the oscillator clock, 0 selects bypass |
| div_more | input | 1 | 1 inserts an extra divide-by-2 stage |
| oe_rst_n | input | 1 | Active-low asynchronous reset and output disable |
| bank_q | output | 5 | Main clock bank, all bits in phase |
| bank_qn | output | 1 | Inverted main clock |
| dbl_q | output | 1 | Double-rate clock |
| half_q | output | 1 | Half-rate clock |
| out_en | output | 8 | Per-output drive enables |

## Verification
The assertions assume that `lock_run`, `ref_pick` and `div_more` stay steady while the counter runs, and that the source clock has no glitches. The stimulus changes these controls only while `oe_rst_n` is low. It releases reset half a source period away from any rising edge, and samples 1 ns after each rising edge of the clock that the bench itself knows is selected. All eight combinations of mode, reference and divide setting are swept over 64 source edges. The expected outputs are worked out from the edge count alone.

// File: rtl/clk_fanout_div.sv
module clk_fanout_div #(
  parameter int BANK_W = 5
) (
  input  logic              osc_clk,
  input  logic              ref_a,
  input  logic              ref_b,
  input  logic              ref_pick,
  input  logic              lock_run,
  input  logic              div_more,
  input  logic              oe_rst_n,
  output tri   [BANK_W-1:0] bank_q,
  output tri                bank_qn,
  output tri                dbl_q,
  output tri                half_q,
  output logic [BANK_W+2:0] out_en
);

  localparam int EN_W  = BANK_W + 3;
  localparam int QN_I  = BANK_W;
  localparam int DBL_I = BANK_W + 1;
  localparam int HLF_I = BANK_W + 2;

  logic       ref_clk;
  logic       src_clk;
  logic       pre;
  logic       step;
  logic [2:0] cnt;
  logic       inv;
  logic       main_v;

  assign ref_clk = ref_pick ? ref_b : ref_a;
  assign src_clk = lock_run ? osc_clk : ref_clk;
  assign step    = ~div_more | ~pre;

  always_ff @(posedge src_clk or negedge oe_rst_n) begin
    if (!oe_rst_n) begin
      pre <= 1'b0;
      cnt <= '0;
    end else begin
      pre <= div_more & ~pre;
      if (step) cnt <= cnt + 3'd1;
    end
  end

  assign inv    = ~lock_run;
  assign main_v = cnt[1] ^ inv;
  assign out_en = {EN_W{oe_rst_n}};

  for (genvar i = 0; i < BANK_W; i++) begin : g_bank
    assign bank_q[i] = out_en[i] ? main_v : 1'bz;
  end
  assign bank_qn = out_en[QN_I]  ? ~main_v       : 1'bz;
  assign dbl_q   = out_en[DBL_I] ? cnt[0] ^ inv  : 1'bz;
  assign half_q  = out_en[HLF_I] ? cnt[2] ^ inv  : 1'bz;

  AST_DBL_STEP: assert property (@(posedge src_clk) disable iff (!oe_rst_n)
    step |=> !$stable(cnt[0])); // R3
  AST_MAIN_ON_FALL: assert property (@(posedge src_clk) disable iff (!oe_rst_n)
    !$stable(cnt[1]) |-> $fell(cnt[0])); // R4
  AST_HALF_ON_FALL: assert property (@(posedge src_clk) disable iff (!oe_rst_n)
    !$stable(cnt[2]) |-> $fell(cnt[1])); // R5
  AST_PRE_HOLD: assert property (@(posedge src_clk) disable iff (!oe_rst_n)
    (div_more && pre) |=> $stable(cnt)); // R6

endmodule

// File: tb/tb_clk_fanout_div.sv
module tb_clk_fanout_div;
  logic       osc_clk = 1'b0;
  logic       ref_a = 1'b0;
  logic       ref_b = 1'b0;
  logic       ref_pick = 1'b0;
  logic       lock_run = 1'b1;
  logic       div_more = 1'b0;
  logic       oe_rst_n = 1'b0;
  wire  [4:0] bank_q;
  wire        bank_qn;
  wire        dbl_q;
  wire        half_q;
  logic [7:0] out_en;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4  osc_clk = ~osc_clk;
  always #10 ref_a   = ~ref_a;
  always #14 ref_b   = ~ref_b;

  clk_fanout_div dut (
    .osc_clk(osc_clk), .ref_a(ref_a), .ref_b(ref_b), .ref_pick(ref_pick),
    .lock_run(lock_run), .div_more(div_more), .oe_rst_n(oe_rst_n),
    .bank_q(bank_q), .bank_qn(bank_qn), .dbl_q(dbl_q), .half_q(half_q),
    .out_en(out_en)
  );

  wire tb_src = lock_run ? osc_clk : (ref_pick ? ref_b : ref_a);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (lock=%0b pick=%0b div=%0b)",
               req, act, exp, lock_run, ref_pick, div_more);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #30;
    chk("R9 reset enables", out_en, 8'h00);
    for (int c = 0; c < 8; c++) begin
      oe_rst_n = 1'b0;
      lock_run = c[2];
      ref_pick = c[1];
      div_more = c[0];
      #60;
      chk("R9 enables off", out_en, 8'h00);
      @(negedge tb_src);
      oe_rst_n = 1'b1;
      #1;
      chk("R9 enables on", out_en, 8'hFF);
      for (int e = 1; e <= 64; e++) begin
        @(posedge tb_src);
        #1;
        begin
          int   k;
          logic inv;
          logic [2:0] s;
          k   = div_more ? (e + 1) / 2 : e;
          s   = k[2:0];
          inv = ~lock_run;
          // R1 R2 R6 R10: step count follows the bench-selected clock
          chk(lock_run ? "R2 R3 dbl" : "R1 R7 R3 dbl", {7'd0, dbl_q},  {7'd0, s[0] ^ inv});
          chk(div_more ? "R6 R4 bank" : "R10 R4 bank", {3'd0, bank_q}, {3'd0, {5{s[1] ^ inv}}});
          chk("R8 bank_qn", {7'd0, bank_qn}, {7'd0, ~(s[1] ^ inv)});
          chk("R5 R7 half", {7'd0, half_q}, {7'd0, s[2] ^ inv});
        end
      end
    end
    oe_rst_n = 1'b0;
    #5;
    chk("R9 final disable", out_en, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule